// File: doc/BRIEF.md
# TLB Miss Assist Preloader

When a translation lookup misses, a software handler has to build a new TLB entry. This block saves it most of the work. On the miss pulse it fills six assist registers in one clock edge. The values come from the missed page number, the kind of access, the address-space context, the current process IDs and a set of default fields. The handler then only adjusts what differs from the defaults and issues its TLB write.

A round-robin victim counter suggests where the new entry should go. Each miss reports the current way as the entry select and the following way as the next-victim hint. The counter then advances. The TLB write and any page-table walk sit outside this block.

Top module: `miss_assist_loader`

## Requirements
- R1: After reset every assist output reads zero, and the first miss reports way 0 as its entry select.
- R2: While `missPulse` is low, every assist output holds its value whatever the other inputs do.
- R3: On a miss, the fields are loaded from the defaults and the rest are cleared:
  - `asst0[1:0]` takes `defArray`.
  - `asst1[11:8]` takes `defSize`.
  - `asst2[4:0]` takes `defAttr`.
  - `asst3` and `asst7` become zero.
  - All bits of every register not named in R3 to R9 become zero.
- R4: On a miss, the valid bit `asst1[31]` is set and `asst2[31:12]` takes `missPage`.
- R5: The effective space bit is written to both `asst1[12]` and `asst6[0]`. It is chosen as follows:
  - A fetch (`isFetch`=1) uses `instSpace`.
  - A data access in external-ID mode uses `extSpace`.
  - Any other data access uses `dataSpace`.
- R6: In normal mode, `asst1[29:16]` holds the translation ID picked by `defTidSel`: 0 gives `pid0`, 1 gives `pid1`, 2 gives `pid2`, and 3 gives zero.
- R7: In normal mode, `asst6[29:16]` holds `pid0`, whatever the selector value.
- R8: In external-ID mode (`extIdMode`=1), both `asst1[29:16]` and `asst6[29:16]` take `extId`, and `defTidSel` is ignored.
- R9: On each miss:
  - `asst0[15:8]` holds the current victim way.
  - `asst0[23:16]` holds that way plus one, modulo WAYS (WAYS is a power of two, default 4).
  - The counter advances by exactly one per miss and wraps to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| missPulse | input | 1 | One-cycle miss strobe |
| missPage | input | 20 | Page-number bits of the missed address |
| isFetch | input | 1 | Access was an instruction fetch |
| dataSpace | input | 1 | Data address-space bit of the context |
| instSpace | input | 1 | Instruction address-space bit of the context |
| extIdMode | input | 1 | Access uses an external process ID |
| extId | input | PID_W (14) | External process ID |
| extSpace | input | 1 | Address space given with the external ID |
| pid0 | input | PID_W (14) | Primary process ID |
| pid1 | input | PID_W (14) | Second process ID |
| pid2 | input | PID_W (14) | Third process ID |
| defArray | input | 2 | Default TLB array select |
| defSize | input | 4 | Default page-size code |
| defAttr | input | 5 | Default cache-attribute bits |
| defTidSel | input | 2 | Default translation-ID selector |
| asst0 | output | 32 | Assist register 0: array, entry select, next victim |
| asst1 | output | 32 | Assist register 1: valid, ID, space, size |
| asst2 | output | 32 | Assist register 2: page number, attributes |
| asst3 | output | 32 | Assist register 3 (cleared) |
| asst6 | output | 32 | Assist register 6: search ID and search space |
| asst7 | output | 32 | Assist register 7 (cleared) |

## Verification
The bench covers all four selector values, including the reserved one that must yield zero. A design that fell through to a PID there would show a stale ID in `asst1`. It also drives a fetch with the two space bits set to opposite values, so a design that used the data-space bit for fetches would flip `asst1[12]` and `asst6[0]`. Six misses in a row check that the victim counter wraps, and an off-by-one or a missing wrap would show up in the entry-select or hint fields. External-ID mode runs with a selector that would otherwise pick `pid1`, and idle cycles with changed inputs catch any register that loads without a pulse.

// File: rtl/miss_assist_pkg.sv
package miss_assist_pkg;
  localparam int REG_W       = 32;
  localparam int PAGE_W      = 20;
  localparam int PAGE_LSB    = 12;
  localparam int FIELD_W     = 8;
  localparam int ESEL_LSB    = 8;
  localparam int NV_LSB      = 16;
  localparam int VALID_BIT   = 31;
  localparam int SPACE_BIT   = 12;
  localparam int SIZE_LSB    = 8;
  localparam int ID_LSB      = 16;
  localparam int SSPACE_BIT  = 0;

  typedef struct packed {
    logic               load;
    logic [FIELD_W-1:0] esel;
    logic [FIELD_W-1:0] nextVictim;
  } strobe_t;
endpackage

// File: rtl/miss_assist_ctrl.sv
module miss_assist_ctrl
  import miss_assist_pkg::*;
#(
  parameter int WAYS = 4
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    missPulse,
  output strobe_t stb
);
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

  logic [WAY_W-1:0] victim;
  logic [WAY_W-1:0] victimNext;

  assign victimNext = victim + 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      victim <= '0;
    end else if (missPulse) begin
      victim <= victimNext;
    end
  end

  always_comb begin
    stb            = '0;
    stb.load       = missPulse;
    stb.esel       = FIELD_W'(victim);
    stb.nextVictim = FIELD_W'(victimNext);
  end
endmodule

// File: rtl/miss_assist_dp.sv
module miss_assist_dp
  import miss_assist_pkg::*;
#(
  parameter int PID_W = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [PAGE_W-1:0] missPage,
  input  logic              isFetch,
  input  logic              dataSpace,
  input  logic              instSpace,
  input  logic              extIdMode,
  input  logic [PID_W-1:0]  extId,
  input  logic              extSpace,
  input  logic [PID_W-1:0]  pid0,
  input  logic [PID_W-1:0]  pid1,
  input  logic [PID_W-1:0]  pid2,
  input  logic [1:0]        defArray,
  input  logic [3:0]        defSize,
  input  logic [4:0]        defAttr,
  input  logic [1:0]        defTidSel,
  output logic [REG_W-1:0]  asst0,
  output logic [REG_W-1:0]  asst1,
  output logic [REG_W-1:0]  asst2,
  output logic [REG_W-1:0]  asst3,
  output logic [REG_W-1:0]  asst6,
  output logic [REG_W-1:0]  asst7
);
  logic             effSpace;
  logic [PID_W-1:0] selTid;
  logic [PID_W-1:0] missTid;
  logic [PID_W-1:0] searchId;
  logic [REG_W-1:0] n0, n1, n2, n6;

  always_comb begin
    if (isFetch)        effSpace = instSpace;
    else if (extIdMode) effSpace = extSpace;
    else                effSpace = dataSpace;
  end

  always_comb begin
    unique case (defTidSel)
      2'd0:    selTid = pid0;
      2'd1:    selTid = pid1;
      2'd2:    selTid = pid2;
      default: selTid = '0;
    endcase
  end

  assign missTid  = extIdMode ? extId : selTid;
  assign searchId = extIdMode ? extId : pid0;

  always_comb begin
    n0 = '0;
    n0[1:0]                  = defArray;
    n0[ESEL_LSB +: FIELD_W]  = stb.esel;
    n0[NV_LSB +: FIELD_W]    = stb.nextVictim;

    n1 = '0;
    n1[VALID_BIT]            = 1'b1;
    n1[SPACE_BIT]            = effSpace;
    n1[SIZE_LSB +: 4]        = defSize;
    n1[ID_LSB +: PID_W]      = missTid;

    n2 = '0;
    n2[PAGE_LSB +: PAGE_W]   = missPage;
    n2[4:0]                  = defAttr;

    n6 = '0;
    n6[SSPACE_BIT]           = effSpace;
    n6[ID_LSB +: PID_W]      = searchId;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      asst0 <= '0;
      asst1 <= '0;
      asst2 <= '0;
      asst6 <= '0;
    end else if (stb.load) begin
      asst0 <= n0;
      asst1 <= n1;
      asst2 <= n2;
      asst6 <= n6;
    end
  end

  assign asst3 = '0;
  assign asst7 = '0;
endmodule

// File: rtl/miss_assist_loader.sv
module miss_assist_loader
  import miss_assist_pkg::*;
#(
  parameter int WAYS  = 4,
  parameter int PID_W = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              missPulse,
  input  logic [19:0]       missPage,
  input  logic              isFetch,
  input  logic              dataSpace,
  input  logic              instSpace,
  input  logic              extIdMode,
  input  logic [PID_W-1:0]  extId,
  input  logic              extSpace,
  input  logic [PID_W-1:0]  pid0,
  input  logic [PID_W-1:0]  pid1,
  input  logic [PID_W-1:0]  pid2,
  input  logic [1:0]        defArray,
  input  logic [3:0]        defSize,
  input  logic [4:0]        defAttr,
  input  logic [1:0]        defTidSel,
  output logic [31:0]       asst0,
  output logic [31:0]       asst1,
  output logic [31:0]       asst2,
  output logic [31:0]       asst3,
  output logic [31:0]       asst6,
  output logic [31:0]       asst7
);
  strobe_t stb;

  miss_assist_ctrl #(.WAYS(WAYS)) uCtrl (
    .clk(clk), .rstN(rstN), .missPulse(missPulse), .stb(stb)
  );

  miss_assist_dp #(.PID_W(PID_W)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .missPage(missPage), .isFetch(isFetch),
    .dataSpace(dataSpace), .instSpace(instSpace),
    .extIdMode(extIdMode), .extId(extId), .extSpace(extSpace),
    .pid0(pid0), .pid1(pid1), .pid2(pid2),
    .defArray(defArray), .defSize(defSize), .defAttr(defAttr),
    .defTidSel(defTidSel),
    .asst0(asst0), .asst1(asst1), .asst2(asst2),
    .asst3(asst3), .asst6(asst6), .asst7(asst7)
  );
endmodule

// File: rtl/miss_assist_loader_chk.sv
module miss_assist_loader_chk #(
  parameter int WAYS  = 4,
  parameter int PID_W = 14
) (
  input logic             clk,
  input logic             rstN,
  input logic             missPulse,
  input logic [19:0]      missPage,
  input logic             extIdMode,
  input logic [PID_W-1:0] extId,
  input logic [31:0]      asst0,
  input logic [31:0]      asst1,
  input logic [31:0]      asst2,
  input logic [31:0]      asst6
);
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

  logic [WAY_W-1:0] eselObs;
  logic [WAY_W-1:0] nvObs;
  assign eselObs = asst0[8 +: WAY_W];
  assign nvObs   = asst0[16 +: WAY_W];

  // R2
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !missPulse |=> ($stable(asst0) && $stable(asst1) && $stable(asst2) && $stable(asst6)));

  // R4
  valid_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    missPulse |=> asst1[31]);

  // R4
  page_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    missPulse |=> asst2[31:12] == $past(missPage));

  // R8
  ext_id_chk: assert property (@(posedge clk) disable iff (!rstN)
    (missPulse && extIdMode) |=>
      (asst1[16 +: PID_W] == $past(extId) && asst6[16 +: PID_W] == $past(extId)));

  // R9
  hint_follows_chk: assert property (@(posedge clk) disable iff (!rstN)
    missPulse |=> nvObs == WAY_W'(eselObs + 1'b1));
endmodule

bind miss_assist_loader miss_assist_loader_chk #(.WAYS(WAYS), .PID_W(PID_W)) uChk (
  .clk(clk), .rstN(rstN), .missPulse(missPulse), .missPage(missPage),
  .extIdMode(extIdMode), .extId(extId),
  .asst0(asst0), .asst1(asst1), .asst2(asst2), .asst6(asst6)
);

// File: tb/miss_assist_loader_test.sv
module miss_assist_loader_test;
  localparam int WAYS  = 4;
  localparam int PID_W = 14;

  logic clk = 0;
  logic rstN = 0;
  logic missPulse = 0;
  logic [19:0] missPage = '0;
  logic isFetch = 0, dataSpace = 0, instSpace = 0, extIdMode = 0, extSpace = 0;
  logic [PID_W-1:0] extId = '0, pid0 = '0, pid1 = '0, pid2 = '0;
  logic [1:0] defArray = '0, defTidSel = '0;
  logic [3:0] defSize = '0;
  logic [4:0] defAttr = '0;
  logic [31:0] asst0, asst1, asst2, asst3, asst6, asst7;

  int checks = 0;
  int errors = 0;
  int missCount = 0;
  bit done = 0;

  miss_assist_loader #(.WAYS(WAYS), .PID_W(PID_W)) uut (.*);

  always #10 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic pulseMiss();
    @(negedge clk);
    missPulse = 1;
    @(negedge clk);
    missPulse = 0;
    missCount++;
  endtask

  // expected values from the requirement text
  task automatic checkAll(input string req);
    logic sp;
    logic [PID_W-1:0] tid, sid;
    logic [31:0] e0, e1, e2, e6;
    int way;
    sp = isFetch ? instSpace : (extIdMode ? extSpace : dataSpace);
    case (defTidSel)
      2'd0: tid = pid0;
      2'd1: tid = pid1;
      2'd2: tid = pid2;
      default: tid = '0;
    endcase
    sid = pid0;
    if (extIdMode) begin tid = extId; sid = extId; end
    way = (missCount - 1) % WAYS;
    e0 = {8'h0, 8'((way + 1) % WAYS), 8'(way), 6'h0, defArray};
    e1 = {1'b1, 1'b0, tid, 3'h0, sp, defSize, 8'h0};
    e2 = {missPage, 7'h0, defAttr};
    e6 = {2'b0, sid, 15'h0, sp};
    check({req, " asst0"}, asst0, e0);
    check({req, " asst1"}, asst1, e1);
    check({req, " asst2"}, asst2, e2);
    check({req, " asst3 R3"}, asst3, 32'h0);
    check({req, " asst6"}, asst6, e6);
    check({req, " asst7 R3"}, asst7, 32'h0);
  endtask

  task automatic setCtx(input logic [1:0] sel, input logic fetch, input logic ds,
                        input logic is, input logic ext);
    @(negedge clk);
    defTidSel = sel; isFetch = fetch; dataSpace = ds; instSpace = is; extIdMode = ext;
  endtask

  task automatic testReset();
    @(negedge clk);
    check("R1 asst0", asst0, 0);
    check("R1 asst1", asst1, 0);
    check("R1 asst2", asst2, 0);
    check("R1 asst6", asst6, 0);
  endtask

  task automatic testSelectors();
    for (int s = 0; s < 4; s++) begin
      setCtx(2'(s), 0, s[0], ~s[0], 0);
      missPage = 20'hA5000 + 20'(s);
      defArray = 2'(s); defSize = 4'(9 + s); defAttr = 5'(s * 7);
      pulseMiss();
      checkAll($sformatf("R6 R3 R4 R7 R9 sel%0d", s));
    end
  endtask

  task automatic testFetch();
    setCtx(2'd1, 1, 0, 1, 0);
    missPage = 20'h12345;
    pulseMiss();
    checkAll("R5 fetch inst1");
    setCtx(2'd1, 1, 1, 0, 0);
    pulseMiss();
    checkAll("R5 fetch inst0");
  endtask

  task automatic testExt();
    setCtx(2'd1, 0, 0, 0, 1);
    extId = 14'h2ABC; extSpace = 1;
    missPage = 20'hFFFFF;
    pulseMiss();
    checkAll("R8 ext space1");
    @(negedge clk);
    extSpace = 0; extId = 14'h0011;
    pulseMiss();
    checkAll("R8 ext space0");
    @(negedge clk);
    extIdMode = 0;
  endtask

  task automatic testHold();
    logic [31:0] h0, h1, h2, h6;
    h0 = asst0; h1 = asst1; h2 = asst2; h6 = asst6;
    @(negedge clk);
    missPage = 20'h00001; pid0 = 14'h3FFF; defArray = 2'd3; defAttr = 5'h1F;
    repeat (4) @(negedge clk);
    check("R2 hold asst0", asst0, h0);
    check("R2 hold asst1", asst1, h1);
    check("R2 hold asst2", asst2, h2);
    check("R2 hold asst6", asst6, h6);
  endtask

  task automatic testWrap();
    setCtx(2'd0, 0, 1, 0, 0);
    for (int k = 0; k < 6; k++) begin
      missPage = 20'(k * 4099);
      pulseMiss();
      checkAll($sformatf("R9 wrap step%0d", k));
    end
  endtask

  initial begin
    pid0 = 14'h0123; pid1 = 14'h1456; pid2 = 14'h2789;
    repeat (3) @(negedge clk);
    rstN = 1;
    testReset();
    testSelectors();
    testFetch();
    testExt();
    testHold();
    testWrap();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule